// File: doc/BRIEF.md
# Multi-Mode Timer/Counter Channel

This block is one timer/counter channel whose count lives in two byte registers, an upper byte and a lower byte. A two-bit mode field arranges these bytes in one of four ways. They can form a 13-bit count over a 5-bit prescaler, a full 16-bit count, or an 8-bit count that reloads itself. The fourth setting freezes the count. Each count step comes from one of two sources. In timer use, the source is an external machine-cycle strobe. In counter use, it is a falling edge on an external pin, sampled once per strobe.

A run bit starts and stops the channel. When the gate option is on, the channel also needs an external gate pin held high to run. Software loads either byte through its own write strobe and can read both bytes at any time. When the count wraps, an overflow flag is set. The flag stays set until software clears it. The control inputs are plain level signals. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `tmr_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, both count bytes read 0x00 and the overflow flag is 0.
- R2: With the counter-select input at 0 (timer use), the enabled count advances by exactly one step on each clock where the machine-cycle strobe is 1. It does not move on clocks where the strobe is 0.
- R3: With the counter-select input at 1 (counter use), the pin is sampled on every strobe. The count advances by one only on a strobe where the previous sample was 1 and the current pin value is 0. The sample register is 0 after reset.
- R4: While the run bit is 0, neither byte changes except through a write.
- R5: While the gate bit is 1, the count advances only when the gate pin is 1. While the gate bit is 0, the gate pin has no effect.
- R6: Mode 2'b00 (13-bit) works as follows. Bits [4:0] of the lower byte form a prescaler. Each time the prescaler wraps from 31 to 0, the upper byte increments by one. Bits [7:5] of the lower byte are held. When the upper byte wraps from 0xFF to 0x00, the overflow flag is set.
- R7: Mode 2'b01 (16-bit) counts {upper,lower} as one value from 0xFFFF to 0x0000. That wrap sets the overflow flag.
- R8: Mode 2'b10 (auto-reload) counts only the lower byte. A step from 0xFF loads the lower byte with the upper byte and sets the overflow flag. The upper byte is unchanged.
- R9: Mode 2'b11 holds both bytes unchanged.
- R10: The overflow flag stays 1 until a cycle with the clear input at 1. If an overflow and a clear fall in the same cycle, the flag ends at 1.
- R11: A write to either byte appears on that byte's read port on the next clock. In the cycle of any write, no counting takes place in either byte and no overflow is raised.
- R12: The read ports show the live count bytes with no added delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| run_en | input | 1 | Run bit |
| gate_en | input | 1 | Gate option: when 1, gate_pin must also be high for the channel to run |
| ext_sel | input | 1 | 0 = count strobes, 1 = count pin falling edges |
| mode_sel | input | 2 | Count arrangement: 00 = 13-bit, 01 = 16-bit, 10 = 8-bit reload, 11 = hold |
| cnt_pin | input | 1 | External count pin |
| gate_pin | input | 1 | External gate pin |
| hi_wr | input | 1 | Write strobe for the upper byte |
| lo_wr | input | 1 | Write strobe for the lower byte |
| wr_data | input | 8 | Write data for both bytes |
| hi_rd | output | 8 | Live upper byte |
| lo_rd | output | 8 | Live lower byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Software clear of the overflow flag |

## Verification
Two pairs of events can fall in the same cycle. The first pair is an overflow and a software clear of the flag. The bench provokes it by holding the clear input high while a reload-mode count steps past 0xFF on every clock, and it expects the flag to read 1 afterwards. The second pair is a byte write and a count step. The bench provokes it by writing the lower byte while strobes arrive on every clock, and it expects the written value, not the incremented one, on the next clock. In both cases a behavioural model is compared with the read ports on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_PRESC13 = 2'b00,
    MODE_FULL16  = 2'b01,
    MODE_RELOAD8 = 2'b10,
    MODE_HOLD    = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/tmr_event.sv
module tmr_event (
  input  logic clk,
  input  logic rst_n,
  input  logic mc_tick,
  input  logic ext_sel,
  input  logic cnt_pin,
  input  logic run_en,
  input  logic gate_en,
  input  logic gate_pin,
  output logic step
);
  logic samp_q;
  logic fall_seen;
  logic src_evt;
  logic allowed;

  // pin sampled once per machine cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       samp_q <= 1'b0;
    else if (mc_tick) samp_q <= cnt_pin;
  end

  assign fall_seen = samp_q & ~cnt_pin;
  assign src_evt   = ext_sel ? (mc_tick & fall_seen) : mc_tick;
  assign allowed   = run_en & (~gate_en | gate_pin);
  assign step      = src_evt & allowed;

  // R3: an edge-counted step never occurs while the pin is high
  a_r3_step_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && step) |-> !cnt_pin);
  // R5: with gating on, a low gate pin blocks stepping
  a_r5_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !gate_pin) |-> !step);
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRESC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode,
  input  logic              step,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] hi_q,
  output logic [BYTE_W-1:0] lo_q,
  output logic              wrap
);
  localparam int FULL_W = 2 * BYTE_W;

  logic [BYTE_W-1:0]  hi_n, lo_n;
  logic [PRESC_W:0]   p_sum;
  logic [BYTE_W:0]    h_sum;
  logic [BYTE_W:0]    l_sum;
  logic [FULL_W:0]    f_sum;
  logic [FULL_W-1:0]  full_q;
  logic               any_wr;

  assign any_wr = hi_wr | lo_wr;
  assign full_q = {hi_q, lo_q};
  assign p_sum  = {1'b0, lo_q[PRESC_W-1:0]} + (PRESC_W+1)'(1);
  assign h_sum  = {1'b0, hi_q} + (BYTE_W+1)'(1);
  assign l_sum  = {1'b0, lo_q} + (BYTE_W+1)'(1);
  assign f_sum  = {1'b0, full_q} + (FULL_W+1)'(1);

  always_comb begin
    hi_n = hi_q;
    lo_n = lo_q;
    wrap = 1'b0;
    if (any_wr) begin
      if (hi_wr) hi_n = wr_data;
      if (lo_wr) lo_n = wr_data;
    end else if (step) begin
      unique case (mode)
        MODE_PRESC13: begin
          lo_n = {lo_q[BYTE_W-1:PRESC_W], p_sum[PRESC_W-1:0]};
          if (p_sum[PRESC_W]) begin
            hi_n = h_sum[BYTE_W-1:0];
            wrap = h_sum[BYTE_W];
          end
        end
        MODE_FULL16: begin
          {hi_n, lo_n} = f_sum[FULL_W-1:0];
          wrap         = f_sum[FULL_W];
        end
        MODE_RELOAD8: begin
          if (l_sum[BYTE_W]) begin
            lo_n = hi_q;
            wrap = 1'b1;
          end else begin
            lo_n = l_sum[BYTE_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_n;
      lo_q <= lo_n;
    end
  end

  // R9: hold mode freezes both bytes when no write occurs
  a_r9_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD && !any_wr) |=> (full_q == $past(full_q)));
  // R7: a 16-bit step below the top value adds exactly one
  a_r7_full_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FULL16 && step && !any_wr && full_q != '1)
      |=> (full_q == $past(full_q) + FULL_W'(1)));
  // R8: reload takes the upper byte and leaves it unchanged
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RELOAD8 && step && !any_wr && lo_q == '1)
      |=> (lo_q == $past(hi_q) && hi_q == $past(hi_q)));
  // R6: the bits above the prescaler are untouched by counting
  a_r6_upper_lo_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PRESC13 && !any_wr)
      |=> (lo_q[BYTE_W-1:PRESC_W] == $past(lo_q[BYTE_W-1:PRESC_W])));
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  // R10: the flag is sticky without a clear
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  // R10: a set in the same cycle as a clear wins
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> flag_q);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRESC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic              run_en,
  input  logic              gate_en,
  input  logic              ext_sel,
  input  logic [1:0]        mode_sel,
  input  logic              cnt_pin,
  input  logic              gate_pin,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] hi_rd,
  output logic [BYTE_W-1:0] lo_rd,
  output logic              ovf_flag,
  input  logic              ovf_clr
);
  logic step;
  logic wrap;
  tmr_mode_e mode;

  assign mode = tmr_mode_e'(mode_sel);

  tmr_event u_event (
    .clk      (clk),
    .rst_n    (rst_n),
    .mc_tick  (mc_tick),
    .ext_sel  (ext_sel),
    .cnt_pin  (cnt_pin),
    .run_en   (run_en),
    .gate_en  (gate_en),
    .gate_pin (gate_pin),
    .step     (step)
  );

  tmr_count #(.BYTE_W(BYTE_W), .PRESC_W(PRESC_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .step    (step),
    .hi_wr   (hi_wr),
    .lo_wr   (lo_wr),
    .wr_data (wr_data),
    .hi_q    (hi_rd),
    .lo_q    (lo_rd),
    .wrap    (wrap)
  );

  tmr_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (wrap),
    .clr_i  (ovf_clr),
    .flag_q (ovf_flag)
  );

  // R1: reset leaves bytes and flag cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (hi_rd == '0 && lo_rd == '0 && !ovf_flag));
  // R4: a stopped channel does not move without a write
  a_r4_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !hi_wr && !lo_wr) |=> ($stable(hi_rd) && $stable(lo_rd)));
  // R2: no strobe, no movement
  a_r2_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_tick && !hi_wr && !lo_wr) |=> ($stable(hi_rd) && $stable(lo_rd)));
  // R11: a written byte shows up on the next clock
  a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> (lo_rd == $past(wr_data)));
endmodule

// File: tb/tb_tmr_unit.sv
module tb_tmr_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_tick = 1'b0;
  logic       run_en = 1'b0, gate_en = 1'b0, ext_sel = 1'b0;
  logic [1:0] mode_sel = 2'b01;
  logic       cnt_pin = 1'b0, gate_pin = 1'b0;
  logic       hi_wr = 1'b0, lo_wr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] hi_rd, lo_rd;
  logic       ovf_flag;
  logic       ovf_clr = 1'b0;

  int checks = 0, errors = 0;
  int tick_per = 1, tick_ctr = 0;
  int cyc = 0;
  string cur_req = "R1";

  int m_hi = 0, m_lo = 0, m_flag = 0, m_samp = 0;

  always #2.5 clk = ~clk;

  tmr_unit dut (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .run_en(run_en),
    .gate_en(gate_en), .ext_sel(ext_sel), .mode_sel(mode_sel),
    .cnt_pin(cnt_pin), .gate_pin(gate_pin), .hi_wr(hi_wr), .lo_wr(lo_wr),
    .wr_data(wr_data), .hi_rd(hi_rd), .lo_rd(lo_rd), .ovf_flag(ovf_flag),
    .ovf_clr(ovf_clr)
  );

  // behavioural reference, written from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_flag = 0; m_samp = 0;   // R1
    end else begin
      int  v, p;
      bit  fall, evt, en, ov;
      fall = (m_samp == 1) && !cnt_pin;
      evt  = ext_sel ? (mc_tick && fall) : mc_tick;  // R2 R3
      if (mc_tick) m_samp = cnt_pin;
      en = run_en && (!gate_en || gate_pin);         // R4 R5
      ov = 0;
      if (hi_wr || lo_wr) begin                      // R11
        if (hi_wr) m_hi = wr_data;
        if (lo_wr) m_lo = wr_data;
      end else if (en && evt) begin
        case (mode_sel)
          2'b00: begin                               // R6
            p = (m_lo % 32) + 1;
            if (p == 32) begin
              p = 0;
              m_hi = m_hi + 1;
              if (m_hi == 256) begin m_hi = 0; ov = 1; end
            end
            m_lo = (m_lo / 32) * 32 + p;
          end
          2'b01: begin                               // R7
            v = m_hi * 256 + m_lo + 1;
            if (v == 65536) begin v = 0; ov = 1; end
            m_hi = v / 256; m_lo = v % 256;
          end
          2'b10: begin                               // R8
            if (m_lo == 255) begin m_lo = m_hi; ov = 1; end
            else m_lo = m_lo + 1;
          end
          default: ;                                 // R9
        endcase
      end
      if (ov) m_flag = 1;                            // R10
      else if (ovf_clr) m_flag = 0;
    end
  end

  // machine-cycle strobe generator
  always @(negedge clk) begin
    if (tick_ctr >= tick_per - 1) begin mc_tick = 1'b1; tick_ctr = 0; end
    else begin mc_tick = 1'b0; tick_ctr = tick_ctr + 1; end
  end

  // per-cycle comparison, away from the active edge (R12: reads are live)
  always @(negedge clk) begin
    checks = checks + 1;
    if (hi_rd !== m_hi[7:0] || lo_rd !== m_lo[7:0] || ovf_flag !== m_flag[0]) begin
      errors = errors + 1;
      $display("FAIL %s cycle %0d: got hi=%02h lo=%02h flag=%0b, expected hi=%02h lo=%02h flag=%0d",
               cur_req, cyc, hi_rd, lo_rd, ovf_flag, m_hi[7:0], m_lo[7:0], m_flag);
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: got cycle %0d, expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] h, input logic [7:0] l);
    @(negedge clk); hi_wr = 1'b1; lo_wr = 1'b0; wr_data = h;
    @(negedge clk); hi_wr = 1'b0; lo_wr = 1'b1; wr_data = l;
    @(negedge clk); lo_wr = 1'b0;
  endtask

  task automatic expect_bytes(input string req, input int h, input int l, input int f);
    checks = checks + 1;
    if (hi_rd !== h[7:0] || lo_rd !== l[7:0] || ovf_flag !== f[0]) begin
      errors = errors + 1;
      $display("FAIL %s: got hi=%02h lo=%02h flag=%0b, expected hi=%02h lo=%02h flag=%0d",
               req, hi_rd, lo_rd, ovf_flag, h[7:0], l[7:0], f);
    end
  endtask

  initial begin
    cur_req = "R1";
    wait_cyc(3);
    expect_bytes("R1", 0, 0, 0);
    rst_n = 1'b1;
    wait_cyc(2);
    expect_bytes("R1", 0, 0, 0);

    // R7: 16-bit wrap with slow strobes
    cur_req = "R7"; mode_sel = 2'b01; tick_per = 3;
    load(8'hFF, 8'hF0);
    run_en = 1'b1;
    wait_cyc(60);
    // R10: flag held without clear
    cur_req = "R10"; run_en = 1'b0;
    wait_cyc(5);
    expect_bytes("R10", m_hi, m_lo, 1);
    ovf_clr = 1'b1; wait_cyc(1); ovf_clr = 1'b0; wait_cyc(1);

    // R2: timer steps on each strobe
    cur_req = "R2"; tick_per = 2; load(8'h12, 8'h34); run_en = 1'b1;
    wait_cyc(20);

    // R6: 13-bit prescaled, upper lo bits set
    cur_req = "R6"; run_en = 1'b0; mode_sel = 2'b00; tick_per = 1;
    load(8'hFE, 8'hE0); run_en = 1'b1;
    wait_cyc(70);

    // R8: auto-reload
    cur_req = "R8"; run_en = 1'b0; ovf_clr = 1'b1; wait_cyc(1); ovf_clr = 1'b0;
    mode_sel = 2'b10; load(8'hF0, 8'hFC); run_en = 1'b1;
    wait_cyc(40);

    // R9: hold
    cur_req = "R9"; mode_sel = 2'b11; wait_cyc(20);

    // R4: run bit off
    cur_req = "R4"; mode_sel = 2'b01; run_en = 1'b0; wait_cyc(15);

    // R5: gating
    cur_req = "R5"; run_en = 1'b1; gate_en = 1'b1; gate_pin = 1'b0; wait_cyc(10);
    gate_pin = 1'b1; wait_cyc(10);
    gate_en = 1'b0; gate_pin = 1'b0; wait_cyc(10);

    // R3: edge counting, several pin patterns
    cur_req = "R3"; ext_sel = 1'b1; tick_per = 2; load(8'h00, 8'h00);
    for (int i = 0; i < 12; i++) begin cnt_pin = ~cnt_pin; wait_cyc(4); end
    for (int i = 0; i < 12; i++) begin cnt_pin = ~cnt_pin; wait_cyc(1); end
    for (int i = 0; i < 8; i++) begin cnt_pin = ~cnt_pin; wait_cyc(3); end
    cnt_pin = 1'b0; wait_cyc(4);
    ext_sel = 1'b0;

    // R10: overflow while clear is held
    cur_req = "R10"; tick_per = 1; mode_sel = 2'b10; run_en = 1'b0;
    load(8'h80, 8'hFD); ovf_clr = 1'b1; run_en = 1'b1;
    wait_cyc(3);
    ovf_clr = 1'b0; run_en = 1'b0; wait_cyc(1);
    expect_bytes("R10", m_hi, m_lo, 1);

    // R11: write collides with a count step
    cur_req = "R11"; mode_sel = 2'b01; run_en = 1'b1; wait_cyc(3);
    lo_wr = 1'b1; wr_data = 8'h55; wait_cyc(1); lo_wr = 1'b0;
    expect_bytes("R11", m_hi, 8'h55, m_flag);
    wait_cyc(5);
    hi_wr = 1'b1; wr_data = 8'hAA; wait_cyc(1); hi_wr = 1'b0;
    expect_bytes("R11", 8'hAA, m_lo, m_flag);
    wait_cyc(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule